// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits behind a synchronous memory bus and interprets write cycles the way a parallel NOR flash with the classic unlock-cycle command set does. Two keyed writes open a command window. The third write selects programming, erasing, identification or the bypass mode. A separate write enters the query table. The sequencer keeps the current phase and the bypass flag. From the phase it picks what a read returns: array words, identification words, a toggling status byte, or bytes of the query table.

A small register array stands in for the flash cells. Programming can only clear bits. Erasing sets either one sector or the whole array back to all ones. The program and erase events are also driven out as request pulses to an external erase/status unit. That unit returns a busy level, and the sequencer stays in its erase phase for as long as busy is high. The data width is 1, 2 or 4 bytes. Bus addresses are byte offsets, and they are scaled to word indices before any decoding.

Top module: `nor_cmd_seq`

## Requirements
- R1: A command is accepted after the byte 0xAA at word 0x555 (UNLOCK0) and then 0x55 at word 0x2AA (UNLOCK1). The command byte goes to UNLOCK0: 0x90 enters identification, 0xA0 enters program, 0x80 starts erase, and 0x20 enters bypass.
- R2: The word index is the byte address shifted right by 0, 1 or 2 for widths of 1, 2 or 4 bytes. Write decoding compares only bits [10:0] of the word index.
- R3: In program mode, the next write stores the old word AND the written word, raises prog_req for that cycle, and returns to read mode (rd_mode 0).
- R4: While bypass is set, the command write is taken at any address with no key writes, and a program returns to the command phase. A 0x00 write in identification under bypass clears bypass and returns to read mode.
- R5: In identification (rd_mode 1), word indices are decoded on their low 8 bits: 0 gives ID0, 1 gives ID1, 2 gives 0, 0x0E gives ID2 and 0x0F gives ID3. Any other word gives array data, and so does 0x0E or 0x0F when that ID has a low byte of 0xFF.
- R6: Writing 0x98 at word 0x55 in read mode enters query mode (rd_mode 3). A read returns the table byte at the low 8 bits of the word index: "QRY" at 0x10..0x12, the log2 of the chip bytes at 0x27, the region count 1 at 0x2C, the sector count minus one at 0x2D..0x2E, and the sector bytes divided by 256 at 0x2F..0x30. Reads at 0x4D and above return 0.
- R7: Writing 0x98 at word 0x55 in identification enters a nested query mode, and a 0xF0 write there goes back to identification.
- R8: After 0x80 a second key pair is needed. Then 0x10 at UNLOCK0 erases the whole array, and 0x30 at any address erases the sector that holds that word. Either one pulses erase_req (erase_chip high for the whole-array erase) and holds the erase phase until busy_i is low.
- R9: A 0xF0 write returns to read mode and clears bypass. This does not apply in the erase phase, where it is ignored, or as the program data write, where it is stored as data.
- R10: A write with an unexpected address or byte returns to read mode and clears bypass, and it changes no array word.
- R11: In the program and erase phases rd_mode is 2, and every read flips bit 6 of the status byte. In the erase phase a read also flips bit 2. The read returns the value after the flip, and the status starts at 0.
- R12: After reset the block is in read mode with the array all ones. A read never advances the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8*BYTES | Write data; the low byte is the command |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8*BYTES | Read data, combinational from the address |
| rd_mode | output | 2 | Read source: 0 array, 1 identification, 2 status, 3 query |
| prog_req | output | 1 | Program write taking place this cycle |
| erase_req | output | 1 | Erase command accepted this cycle |
| erase_chip | output | 1 | The accepted erase is for the whole array |
| erase_sect | output | SECT_W | Sector index of the erase |
| busy_i | input | 1 | Erase unit still working |

## Verification
The assertions assume that read and write strobes are never high together. They also assume that busy_i rises in the cycle after erase_req and stays high until the erase is finished. The bench drives exactly one strobe per cycle, and it changes its inputs only at falling edges. It models the erase unit as a counter that is loaded by erase_req, so busy_i rises on the clock edge that accepts the erase command and falls a fixed number of cycles later.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [3:0] {
    SQ_READ, SQ_UNL1, SQ_CMD, SQ_PROG, SQ_AUTO,
    SQ_EUNL0, SQ_EUNL1, SQ_ECMD, SQ_ERASE, SQ_QRY, SQ_AQRY
  } seq_state_e;

  typedef enum logic [1:0] {
    RM_ARRAY = 2'd0, RM_IDENT = 2'd1, RM_STATUS = 2'd2, RM_QUERY = 2'd3
  } rd_mode_e;

  localparam logic [7:0] C_KEY0 = 8'hAA;
  localparam logic [7:0] C_KEY1 = 8'h55;
  localparam logic [7:0] C_BYP  = 8'h20;
  localparam logic [7:0] C_ERS  = 8'h80;
  localparam logic [7:0] C_AUTO = 8'h90;
  localparam logic [7:0] C_PROG = 8'hA0;
  localparam logic [7:0] C_QRY  = 8'h98;
  localparam logic [7:0] C_RST  = 8'hF0;
  localparam logic [7:0] C_CHIP = 8'h10;
  localparam logic [7:0] C_SECT = 8'h30;
  localparam logic [10:0] QRY_WORD = 11'h055;
  localparam int QRY_LEN = 77;

  // Status bits flipped by one status read.
  function automatic logic [7:0] st_flip(input logic erasing);
    return erasing ? 8'h44 : 8'h40;
  endfunction

  // Query table contents, computed from the geometry.
  function automatic logic [7:0] qry_byte(input logic [7:0] idx, input int chip_log2,
                                          input int nsect, input int sect_bytes);
    logic [15:0] nm1;
    logic [15:0] sb;
    nm1 = 16'(nsect - 1);
    sb  = 16'(sect_bytes >> 8);
    case (idx)
      8'h10: return 8'h51;
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      8'h13: return 8'h02;
      8'h15: return 8'h40;
      8'h1B: return 8'h27;
      8'h1C: return 8'h36;
      8'h1F: return 8'h07;
      8'h21: return 8'h09;
      8'h22: return 8'h0C;
      8'h23: return 8'h01;
      8'h25: return 8'h0A;
      8'h26: return 8'h0D;
      8'h27: return 8'(chip_log2);
      8'h28: return 8'h02;
      8'h2C: return 8'h01;
      8'h2D: return nm1[7:0];
      8'h2E: return nm1[15:8];
      8'h2F: return sb[7:0];
      8'h30: return sb[15:8];
      8'h40: return 8'h50;
      8'h41: return 8'h52;
      8'h42: return 8'h49;
      8'h43: return 8'h31;
      8'h44: return 8'h30;
      8'h46: return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nor_addr_norm.sv
module nor_addr_norm #(
  parameter int ADDR_W = 16,
  parameter int BYTES  = 2
) (
  input  logic [ADDR_W-1:0] byte_addr,
  output logic [ADDR_W-1:0] word_idx,
  output logic [10:0]       cmp11,
  output logic [7:0]        low8
);
  generate
    if (BYTES == 4) begin : g_w4
      assign word_idx = byte_addr >> 2;
    end else if (BYTES == 2) begin : g_w2
      assign word_idx = byte_addr >> 1;
    end else begin : g_w1
      assign word_idx = byte_addr;
    end
  endgenerate
  assign cmp11 = word_idx[10:0];
  assign low8  = word_idx[7:0];
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 512,
  parameter int SECT_WORDS = 128,
  parameter int IDX_W      = $clog2(DEPTH),
  parameter int SECT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              prog_we,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              erase_all,
  input  logic              erase_one,
  input  logic [SECT_W-1:0] erase_sect,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (erase_all || (erase_one && SECT_W'(i / SECT_WORDS) == erase_sect))
          mem_q[i] <= '1;
        else if (prog_we && idx == IDX_W'(i))
          mem_q[i] <= mem_q[i] & prog_data;
      end
    end
  end

  assign rd_word = mem_q[idx];

  // R3: a program never sets a bit that was clear before it
  assert_prog_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> ((mem_q[$past(idx)] & ~$past(rd_word)) == '0));
  // R8: a whole-array erase leaves the addressed word all ones
  assert_chip_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_all |=> (mem_q[$past(idx)] == '1));
endmodule

// File: rtl/nor_query_rom.sv
module nor_query_rom
  import nor_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter logic [15:0] ID0 = 16'h0001,
  parameter logic [15:0] ID1 = 16'h227E,
  parameter logic [15:0] ID2 = 16'h2210,
  parameter logic [15:0] ID3 = 16'h00FF,
  parameter int CHIP_LOG2   = 10,
  parameter int NSECT       = 4,
  parameter int SECT_BYTES  = 256
) (
  input  logic [7:0]        low8,
  input  logic              qry_sel,
  input  logic [DATA_W-1:0] arr_word,
  output logic [DATA_W-1:0] q_word
);
  logic [DATA_W-1:0] id_word;

  always_comb begin
    case (low8)
      8'h00: id_word = DATA_W'(ID0);
      8'h01: id_word = DATA_W'(ID1);
      8'h02: id_word = '0;
      8'h0E: id_word = (ID2[7:0] == 8'hFF) ? arr_word : DATA_W'(ID2);
      8'h0F: id_word = (ID3[7:0] == 8'hFF) ? arr_word : DATA_W'(ID3);
      default: id_word = arr_word;
    endcase
  end

  always_comb begin
    if (!qry_sel) q_word = id_word;
    else if (int'(low8) >= QRY_LEN) q_word = '0;
    else q_word = DATA_W'(qry_byte(low8, CHIP_LOG2, NSECT, SECT_BYTES));
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int BYTES        = 2,
  parameter int DEPTH        = 512,
  parameter int SECT_WORDS   = 128,
  parameter logic [10:0] UNLOCK0 = 11'h555,
  parameter logic [10:0] UNLOCK1 = 11'h2AA,
  parameter logic [15:0] ID0 = 16'h0001,
  parameter logic [15:0] ID1 = 16'h227E,
  parameter logic [15:0] ID2 = 16'h2210,
  parameter logic [15:0] ID3 = 16'h00FF,
  localparam int DATA_W    = 8 * BYTES,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int NSECT     = DEPTH / SECT_WORDS,
  localparam int SECT_W    = (NSECT > 1) ? $clog2(NSECT) : 1,
  localparam int SECT_SH   = $clog2(SECT_WORDS),
  localparam int CHIP_LOG2 = $clog2(DEPTH * BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [1:0]        rd_mode,
  output logic              prog_req,
  output logic              erase_req,
  output logic              erase_chip,
  output logic [SECT_W-1:0] erase_sect,
  input  logic              busy_i
);
  seq_state_e st_q, st_d;
  logic byp_q, byp_d;
  logic [7:0] stat_q, stat_view;
  logic [ADDR_W-1:0] word_idx;
  logic [10:0] cmp11;
  logic [7:0] low8, wb;
  logic [IDX_W-1:0] arr_idx;
  logic [DATA_W-1:0] arr_word, rom_word;
  logic at_u0, at_u1, at_qry, f0_ev, bad;
  logic prog_we, erase_go, chip_go, stat_rd;
  rd_mode_e mode;

  nor_addr_norm #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_norm (
    .byte_addr(bus_addr), .word_idx(word_idx), .cmp11(cmp11), .low8(low8));

  assign arr_idx = word_idx[IDX_W-1:0];
  assign wb      = bus_wdata[7:0];
  assign at_u0   = (cmp11 == UNLOCK0);
  assign at_u1   = (cmp11 == UNLOCK1);
  assign at_qry  = (cmp11 == QRY_WORD);
  assign f0_ev   = bus_wr && wb == C_RST && st_q != SQ_PROG && st_q != SQ_ERASE;

  nor_cell_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SECT_WORDS(SECT_WORDS),
                   .IDX_W(IDX_W), .SECT_W(SECT_W)) u_cells (
    .clk(clk), .rst_n(rst_n), .idx(arr_idx), .prog_we(prog_we), .prog_data(bus_wdata),
    .erase_all(chip_go), .erase_one(erase_go && !chip_go), .erase_sect(erase_sect),
    .rd_word(arr_word));

  nor_query_rom #(.DATA_W(DATA_W), .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3),
                  .CHIP_LOG2(CHIP_LOG2), .NSECT(NSECT), .SECT_BYTES(SECT_WORDS * BYTES)) u_rom (
    .low8(low8), .qry_sel(mode == RM_QUERY), .arr_word(arr_word), .q_word(rom_word));

  // Write decoding: next phase, bypass flag and the one-cycle events.
  always_comb begin
    st_d = st_q;
    byp_d = byp_q;
    prog_we = 1'b0;
    erase_go = 1'b0;
    chip_go = 1'b0;
    bad = 1'b0;
    if (st_q == SQ_ERASE && !busy_i) st_d = byp_q ? SQ_CMD : SQ_READ;
    if (bus_wr) begin
      if (f0_ev) begin
        if (st_q == SQ_AQRY) st_d = SQ_AUTO;
        else bad = 1'b1;
      end else begin
        case (st_q)
          SQ_READ: begin
            if (at_qry && wb == C_QRY) st_d = SQ_QRY;
            else if (at_u0 && wb == C_KEY0) st_d = SQ_UNL1;
            else bad = 1'b1;
          end
          SQ_UNL1: begin
            if (at_u1 && wb == C_KEY1) st_d = SQ_CMD;
            else bad = 1'b1;
          end
          SQ_CMD: begin
            if (!byp_q && !at_u0) bad = 1'b1;
            else begin
              case (wb)
                C_BYP:  byp_d = 1'b1;
                C_ERS:  st_d = SQ_EUNL0;
                C_AUTO: st_d = SQ_AUTO;
                C_PROG: st_d = SQ_PROG;
                default: bad = 1'b1;
              endcase
            end
          end
          SQ_PROG: begin
            prog_we = 1'b1;
            st_d = byp_q ? SQ_CMD : SQ_READ;
          end
          SQ_AUTO: begin
            if (byp_q && wb == 8'h00) bad = 1'b1;
            else if (at_qry && wb == C_QRY) st_d = SQ_AQRY;
            else bad = 1'b1;
          end
          SQ_EUNL0: begin
            if (at_u0 && wb == C_KEY0) st_d = SQ_EUNL1;
            else bad = 1'b1;
          end
          SQ_EUNL1: begin
            if (at_u1 && wb == C_KEY1) st_d = SQ_ECMD;
            else bad = 1'b1;
          end
          SQ_ECMD: begin
            if (wb == C_CHIP && at_u0) begin
              erase_go = 1'b1;
              chip_go = 1'b1;
              st_d = SQ_ERASE;
            end else if (wb == C_SECT) begin
              erase_go = 1'b1;
              st_d = SQ_ERASE;
            end else bad = 1'b1;
          end
          SQ_ERASE: ;
          default: bad = 1'b1;
        endcase
      end
      if (bad) begin
        st_d = SQ_READ;
        byp_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_READ;
      byp_q <= 1'b0;
      stat_q <= 8'h00;
    end else begin
      st_q <= st_d;
      byp_q <= byp_d;
      if (stat_rd) stat_q <= stat_view;
    end
  end

  always_comb begin
    case (st_q)
      SQ_PROG, SQ_ERASE: mode = RM_STATUS;
      SQ_AUTO:           mode = RM_IDENT;
      SQ_QRY, SQ_AQRY:   mode = RM_QUERY;
      default:           mode = RM_ARRAY;
    endcase
  end

  assign stat_view = stat_q ^ st_flip(st_q == SQ_ERASE);
  assign stat_rd   = bus_rd && mode == RM_STATUS;

  always_comb begin
    case (mode)
      RM_ARRAY:  bus_rdata = arr_word;
      RM_STATUS: bus_rdata = DATA_W'(stat_view);
      default:   bus_rdata = rom_word;
    endcase
  end

  assign rd_mode    = mode;
  assign prog_req   = prog_we;
  assign erase_req  = erase_go;
  assign erase_chip = chip_go;
  assign erase_sect = SECT_W'(arr_idx >> SECT_SH);

  // R12: the bus never asserts both strobes in one cycle
  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  // R12: a read leaves the phase and the bypass flag alone
  assert_read_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && st_q != SQ_ERASE) |=> (st_q == $past(st_q) && byp_q == $past(byp_q)));
  // R3: a program outside bypass ends in read mode
  assert_prog_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && !byp_q) |=> (rd_mode == RM_ARRAY && st_q == SQ_READ));
  // R4: a program under bypass returns to the command phase
  assert_bypass_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && byp_q) |=> (st_q == SQ_CMD && byp_q));
  // R8: an accepted erase enters the erase phase
  assert_erase_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> (st_q == SQ_ERASE && rd_mode == RM_STATUS));
  // R9: the erase phase holds against any write while busy
  assert_erase_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_ERASE && busy_i) |=> st_q == SQ_ERASE);
  // R9: a reset byte outside program data and erase drops bypass
  assert_f0_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (f0_ev && st_q != SQ_AQRY) |=> (!byp_q && st_q == SQ_READ));
  // R11: each status read changes the status byte
  assert_status_flips_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ($countones(stat_q ^ $past(stat_q)) >= 1));
endmodule

// File: tb/tb_nor_cmd_seq.sv
`timescale 1ns/1ps
module tb_nor_cmd_seq;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic [1:0] rd_mode;
  logic prog_req, erase_req, erase_chip;
  logic [2:0] erase_sect;
  logic busy_i;
  logic [4:0] busy_cnt = '0;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  nor_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .rd_mode(rd_mode),
    .prog_req(prog_req), .erase_req(erase_req), .erase_chip(erase_chip),
    .erase_sect(erase_sect), .busy_i(busy_i));

  // Erase unit model: busy for 12 cycles after an accepted erase.
  always_ff @(posedge clk) begin
    if (erase_req) busy_cnt <= 5'd12;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1'b1;
  end
  assign busy_i = (busy_cnt != 0);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [15:0] a, input logic [15:0] exp,
                    input logic [1:0] m);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(req, {16'h0, bus_rdata}, {16'h0, exp});
    check(req, {30'h0, rd_mode}, {30'h0, m});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [38:0] mk(input int t, input bit r, input logic [15:0] a,
                                     input logic [15:0] d, input logic [1:0] m);
    return {4'(t), r, a, d, m};
  endfunction

  // {tag, read, byte address, data or expected, expected rd_mode}
  localparam int NV = 77;
  localparam logic [38:0] VEC [NV] = '{
    mk(12,1,16'h0000,16'hFFFF,0),                                   // R12 erased after reset
    mk(1,0,16'h0AAA,16'h00AA,0), mk(1,0,16'h0554,16'h0055,0), mk(1,0,16'h0AAA,16'h00A0,0), // R1
    mk(11,1,16'h0000,16'h0040,2), mk(11,1,16'h0000,16'h0000,2),     // R11 bit 6 flips
    mk(3,0,16'h0010,16'h1234,0), mk(3,1,16'h0010,16'h1234,0),       // R3
    mk(3,0,16'h0AAA,16'h00AA,0), mk(3,0,16'h0554,16'h0055,0), mk(3,0,16'h0AAA,16'h00A0,0),
    mk(3,0,16'h0010,16'h00FF,0), mk(3,1,16'h0010,16'h0034,0),       // R3 AND
    mk(1,0,16'h0AAA,16'h00AA,0), mk(1,0,16'h0554,16'h0055,0), mk(1,0,16'h0AAA,16'h0090,0),
    mk(5,1,16'h0000,16'h0001,1), mk(5,1,16'h0002,16'h227E,1), mk(5,1,16'h0004,16'h0000,1), // R5
    mk(5,1,16'h001C,16'h2210,1), mk(5,1,16'h001E,16'hFFFF,1), mk(5,1,16'h0010,16'h0034,1),
    mk(7,0,16'h00AA,16'h0098,0), mk(7,1,16'h0020,16'h0051,3),       // R7 nested query
    mk(7,0,16'h0000,16'h00F0,0), mk(7,1,16'h0000,16'h0001,1),
    mk(9,0,16'h0000,16'h00F0,0), mk(9,1,16'h0000,16'hFFFF,0),       // R9
    mk(6,0,16'h00AA,16'h0098,0), mk(6,1,16'h0022,16'h0052,3), mk(6,1,16'h0024,16'h0059,3), // R6
    mk(2,1,16'h004E,16'h000A,3), mk(6,1,16'h0058,16'h0001,3), mk(6,1,16'h005A,16'h0003,3),
    mk(6,1,16'h005E,16'h0001,3), mk(6,1,16'h009A,16'h0000,3),
    mk(10,0,16'h0000,16'h0012,0), mk(10,1,16'h0000,16'hFFFF,0),     // R10
    mk(10,0,16'h0AAA,16'h00AA,0), mk(10,0,16'h0556,16'h0055,0), mk(10,0,16'h0AAA,16'h00A0,0),
    mk(10,0,16'h0010,16'h0000,0), mk(10,1,16'h0010,16'h0034,0),
    mk(2,0,16'h1AAB,16'h00AA,0), mk(2,0,16'h0554,16'h0055,0), mk(2,0,16'h0AAA,16'h0090,0), // R2
    mk(2,1,16'h0000,16'h0001,1), mk(2,0,16'h0000,16'h00F0,0),
    mk(12,0,16'h0AAA,16'h00AA,0), mk(12,1,16'h0000,16'hFFFF,0), mk(12,0,16'h0554,16'h0055,0), // R12
    mk(12,1,16'h0002,16'hFFFF,0), mk(12,0,16'h0AAA,16'h0090,0), mk(12,1,16'h0002,16'h227E,1),
    mk(12,0,16'h0000,16'h00F0,0),
    mk(4,0,16'h0AAA,16'h00AA,0), mk(4,0,16'h0554,16'h0055,0), mk(4,0,16'h0AAA,16'h0020,0), // R4
    mk(4,0,16'h0000,16'h00A0,0), mk(4,0,16'h0020,16'h0F0F,0), mk(4,1,16'h0020,16'h0F0F,0),
    mk(9,0,16'h0300,16'h00A0,0), mk(9,0,16'h0020,16'h00F0,0), mk(9,1,16'h0020,16'h0000,0),
    mk(4,0,16'h0100,16'h0090,0), mk(4,1,16'h0000,16'h0001,1), mk(4,0,16'h0000,16'h0000,0),
    mk(4,0,16'h0000,16'h00A0,0), mk(4,0,16'h0040,16'h0000,0), mk(4,1,16'h0040,16'hFFFF,0),
    mk(9,0,16'h0AAA,16'h00AA,0), mk(9,0,16'h0554,16'h0055,0), mk(9,0,16'h0AAA,16'h0020,0),
    mk(9,0,16'h0000,16'h00F0,0), mk(9,0,16'h0000,16'h00A0,0), mk(9,0,16'h0040,16'h0000,0),
    mk(9,1,16'h0040,16'hFFFF,0)
  };

  task automatic keys();
    wr(16'h0AAA, 16'h00AA);
    wr(16'h0554, 16'h0055);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual %0d expected below 20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12", {30'h0, rd_mode}, 32'h0);
    check("R12", {16'h0, bus_rdata}, 32'hFFFF);
    check("R12", {29'h0, prog_req, erase_req, erase_chip}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][34])
        rd($sformatf("R%0d", int'(VEC[i][38:35])), VEC[i][33:18], VEC[i][17:2], VEC[i][1:0]);
      else
        wr(VEC[i][33:18], VEC[i][17:2]);
    end

    // R8 sector erase: program word 0x80 in sector 1, then erase that sector
    keys(); wr(16'h0AAA, 16'h00A0); wr(16'h0100, 16'h1111);
    rd("R3", 16'h0100, 16'h1111, 2'd0);
    keys(); wr(16'h0AAA, 16'h0080); keys();
    bus_addr = 16'h0102; bus_wdata = 16'h0030; bus_wr = 1'b1;
    #1;
    check("R8", {31'h0, erase_req}, 32'h1);
    check("R8", {31'h0, erase_chip}, 32'h0);
    check("R8", {29'h0, erase_sect}, 32'h1);
    @(negedge clk); bus_wr = 1'b0;
    rd("R11", 16'h0000, 16'h0044, 2'd2);
    rd("R11", 16'h0000, 16'h0000, 2'd2);
    wr(16'h0000, 16'h00F0);
    rd("R9", 16'h0000, 16'h0044, 2'd2);
    while (busy_i) @(negedge clk);
    @(negedge clk);
    rd("R8", 16'h0100, 16'hFFFF, 2'd0);
    rd("R8", 16'h0020, 16'h0000, 2'd0);

    // R8 whole-array erase
    keys(); wr(16'h0AAA, 16'h0080); keys();
    bus_addr = 16'h0AAA; bus_wdata = 16'h0010; bus_wr = 1'b1;
    #1;
    check("R8", {30'h0, erase_req, erase_chip}, 32'h3);
    @(negedge clk); bus_wr = 1'b0;
    while (busy_i) @(negedge clk);
    @(negedge clk);
    rd("R8", 16'h0020, 16'hFFFF, 2'd0);
    rd("R8", 16'h0010, 16'hFFFF, 2'd0);
    finish_run();
  end
endmodule